// File: doc/BRIEF.md
# Triggered Delayed Pulse Sequencer

This block turns each edge of an external trigger line into a single output pulse placed a programmable time after the edge. Time is counted in ticks. A prescaler that restarts on every accepted trigger derives the ticks from the system clock. Within one run, a counter climbs from zero. The output goes high when the counter meets the active delay and goes low when it meets delay plus width. The run finishes at that second point.

An internal sequencer shortens the delay by a programmed step after every completed run and never goes below a programmed floor. The width stays fixed, so successive pulses creep towards their triggers. One write port sets five values: start delay, step, floor, width and repeat count. All of them land in shadow registers. They reach the working registers only while no run is in progress, so a pulse that is already being timed is never disturbed. A repeat count replays the same pulse several times within one run before the next update. A trigger edge that arrives during a run is dropped, and a sticky flag records the overrun.

Top module: `trig_pulse_seq`

## Requirements
- R1: The block stays idle with `pulse_o` low until an edge on `trig_in`. Rising and falling edges both start a run.
- R2: With active delay D ticks and P clocks per tick, `pulse_o` rises D*P+1 clock cycles after the clock edge that accepts the trigger.
- R3: With active width W ticks, `pulse_o` stays high for exactly W*P clock cycles. A run without repeats ends (D+W)*P+1 cycles after acceptance.
- R4: A width of zero produces no pulse. The run still lasts D*P+1 cycles and still advances the delay sequence.
- R5: Writes to step, floor, width or repeat made during a run do not change that run. They take effect on the next run.
- R6: After each completed run the delay becomes D minus step. If that result would fall below the floor, the delay becomes the floor and stays there.
- R7: Writing the start delay makes the next run use that value instead of the decremented delay. This holds even when the write happens during a run.
- R8: A repeat count N gives N+1 identical pulses per run, spaced (D+W)*P+1 cycles apart. The delay changes only after the last of them.
- R9: A trigger edge that arrives while a run is in progress is ignored and sets `overrun_o`, which stays set until reset.
- R10: Synchronous reset drives `pulse_o` and `overrun_o` low and loads every register from its parameter default. The delay restarts at the default start value.
- R11: Register addresses are: 0 start delay, 1 step, 2 floor, 3 width, 4 repeat count. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Trigger line; either edge starts a run |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data (repeat uses the low REP_W bits) |
| pulse_o | output | 1 | Registered pulse output |
| overrun_o | output | 1 | Sticky flag: trigger edge dropped during a run |

## Verification
The bench follows the delay sequence down into the floor. A design that clamps wrongly would either wrap to a huge delay or stop one step early. It writes the width and the start delay halfway through a run: a design without shadowing would stretch or move the pulse that is already being timed, and one that loses a pending start write would keep decrementing. It also checks runs with zero width, which must produce no glitch pulse, and runs with several repeats, where a wrong restart would shift the second pulse by a cycle. It fires an extra trigger in the middle of a run, which a weak design would let restart the counter.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_START  = 3'd0,
    REG_STEP   = 3'd1,
    REG_FLOOR  = 3'd2,
    REG_WIDTH  = 3'd3,
    REG_REPEAT = 3'd4
  } tps_reg_e;
endpackage

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] div_q;

      assign tick = run && (div_q == LAST);

      always_ff @(posedge clk) begin
        if (rst || restart || tick) div_q <= '0;
        else if (run)               div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tps_cfg_regs.sv
module tps_cfg_regs
  import tps_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int REP_W     = 4,
  parameter int DEF_START = 20,
  parameter int DEF_STEP  = 4,
  parameter int DEF_FLOOR = 3,
  parameter int DEF_WIDTH = 5,
  parameter int DEF_REP   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             busy,
  input  logic             cycle_done,
  output logic [CNT_W-1:0] act_delay,
  output logic [CNT_W-1:0] act_width,
  output logic [CNT_W-1:0] act_min,
  output logic [REP_W-1:0] act_rep
);
  logic [CNT_W-1:0] sh_start, sh_step, sh_min, sh_width;
  logic [REP_W-1:0] sh_rep;
  logic [CNT_W-1:0] act_step;
  logic             start_pend;

  // saturating step toward the floor
  logic [CNT_W:0]   floor_plus;
  logic [CNT_W-1:0] next_delay;
  assign floor_plus = {1'b0, act_min} + {1'b0, act_step};
  assign next_delay = ({1'b0, act_delay} >= floor_plus) ? (act_delay - act_step) : act_min;

  logic upd;
  assign upd = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_start   <= CNT_W'(DEF_START);
      sh_step    <= CNT_W'(DEF_STEP);
      sh_min     <= CNT_W'(DEF_FLOOR);
      sh_width   <= CNT_W'(DEF_WIDTH);
      sh_rep     <= REP_W'(DEF_REP);
      start_pend <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (tps_reg_e'(cfg_addr))
          REG_START:  sh_start <= cfg_wdata;
          REG_STEP:   sh_step  <= cfg_wdata;
          REG_FLOOR:  sh_min   <= cfg_wdata;
          REG_WIDTH:  sh_width <= cfg_wdata;
          REG_REPEAT: sh_rep   <= cfg_wdata[REP_W-1:0];
          default: ;
        endcase
      end
      if (cfg_we && (tps_reg_e'(cfg_addr) == REG_START)) start_pend <= 1'b1;
      else if (upd)                                       start_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_delay <= CNT_W'(DEF_START);
      act_step  <= CNT_W'(DEF_STEP);
      act_min   <= CNT_W'(DEF_FLOOR);
      act_width <= CNT_W'(DEF_WIDTH);
      act_rep   <= REP_W'(DEF_REP);
    end else if (upd) begin
      act_step  <= sh_step;
      act_min   <= sh_min;
      act_width <= sh_width;
      act_rep   <= sh_rep;
      if (start_pend) act_delay <= sh_start;
    end else if (cycle_done) begin
      act_delay <= next_delay;
    end
  end
endmodule

// File: rtl/tps_pulse_core.sv
module tps_pulse_core #(
  parameter int CNT_W = 16,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             tick,
  input  logic [CNT_W-1:0] act_delay,
  input  logic [CNT_W-1:0] act_width,
  input  logic [REP_W-1:0] act_rep,
  output logic             pre_restart,
  output logic             busy,
  output logic             cycle_done,
  output logic             pulse_o,
  output logic             overrun_o
);
  localparam int CW = CNT_W + 1;

  logic          trig_q;
  logic          edge_seen, accept, at_end;
  logic [CW-1:0] cnt_q, cmp_v, rld_v;
  logic [REP_W-1:0] rep_q;

  assign cmp_v       = {1'b0, act_delay};
  assign rld_v       = {1'b0, act_delay} + {1'b0, act_width};
  assign edge_seen   = trig_in ^ trig_q;
  assign accept      = edge_seen && !busy;
  assign at_end      = busy && (cnt_q == rld_v);
  assign cycle_done  = at_end && (rep_q == '0);
  assign pre_restart = accept || at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q    <= 1'b0;
      busy      <= 1'b0;
      cnt_q     <= '0;
      rep_q     <= '0;
      pulse_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      trig_q  <= trig_in;
      pulse_o <= busy && (cnt_q >= cmp_v) && (cnt_q < rld_v);
      if (edge_seen && busy) overrun_o <= 1'b1;
      if (accept) begin
        busy  <= 1'b1;
        cnt_q <= '0;
        rep_q <= act_rep;
      end else if (at_end) begin
        if (rep_q != '0) begin
          rep_q <= rep_q - 1'b1;
          cnt_q <= '0;
        end else begin
          busy <= 1'b0;
        end
      end else if (busy && tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_pulse_seq.sv
module trig_pulse_seq #(
  parameter int CNT_W     = 16,
  parameter int REP_W     = 4,
  parameter int PRESCALE  = 4,
  parameter int DEF_START = 20,
  parameter int DEF_STEP  = 4,
  parameter int DEF_FLOOR = 3,
  parameter int DEF_WIDTH = 5,
  parameter int DEF_REP   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             pulse_o,
  output logic             overrun_o
);
  logic             busy, cycle_done, tick, pre_restart;
  logic [CNT_W-1:0] act_delay, act_width, act_min;
  logic [REP_W-1:0] act_rep;

  tps_cfg_regs #(
    .CNT_W(CNT_W), .REP_W(REP_W), .DEF_START(DEF_START), .DEF_STEP(DEF_STEP),
    .DEF_FLOOR(DEF_FLOOR), .DEF_WIDTH(DEF_WIDTH), .DEF_REP(DEF_REP)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .cycle_done(cycle_done), .act_delay(act_delay), .act_width(act_width),
    .act_min(act_min), .act_rep(act_rep)
  );

  tps_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .run(busy), .restart(pre_restart), .tick(tick)
  );

  tps_pulse_core #(.CNT_W(CNT_W), .REP_W(REP_W)) u_core (
    .clk(clk), .rst(rst), .trig_in(trig_in), .tick(tick), .act_delay(act_delay),
    .act_width(act_width), .act_rep(act_rep), .pre_restart(pre_restart), .busy(busy),
    .cycle_done(cycle_done), .pulse_o(pulse_o), .overrun_o(overrun_o)
  );
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             cycle_done,
  input logic             pulse_o,
  input logic             overrun_o,
  input logic [CNT_W-1:0] act_delay,
  input logic [CNT_W-1:0] act_width,
  input logic [CNT_W-1:0] act_min
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !pulse_o);

  assert_zero_width_R4: assert property (@(posedge clk) disable iff (rst)
    (act_width == '0) |=> !pulse_o);

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(act_width));

  assert_delay_floor_R6: assert property (@(posedge clk) disable iff (rst)
    cycle_done |=> (act_delay >= $past(act_min)));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(rst) |-> (!pulse_o && !overrun_o));
endmodule

bind trig_pulse_seq tps_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .cycle_done(cycle_done), .pulse_o(pulse_o),
  .overrun_o(overrun_o), .act_delay(act_delay), .act_width(act_width), .act_min(act_min)
);

// File: tb/tb_trig_pulse_seq.sv
module tb_trig_pulse_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P     = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic pulse_o, overrun_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int m_delay, m_step, m_min, m_width, m_rep;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_pulse_seq #(.CNT_W(CNT_W), .REP_W(4), .PRESCALE(P), .DEF_START(20), .DEF_STEP(4),
                   .DEF_FLOOR(3), .DEF_WIDTH(5), .DEF_REP(0)) dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pulse_o(pulse_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_delay(input int d, input int st, input int mn);
    return (d >= mn + st) ? d - st : mn;
  endfunction

  function automatic bit exp_pulse(input int n, input int d, input int w, input int rep);
    int len = (d + w) * P + 1;
    int m = n - 2;
    for (int k = 0; k <= rep; k++)
      if (m >= k*len + d*P && m < k*len + (d+w)*P) return 1'b1;
    return 1'b0;
  endfunction

  task automatic reset_dut();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_delay = 20; m_step = 4; m_min = 3; m_width = 5; m_rep = 0;
    repeat (2) @(negedge clk);
  endtask

  // write while idle and track the model
  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = CNT_W'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      0: m_delay = data;
      1: m_step  = data;
      2: m_min   = data;
      3: m_width = data;
      4: m_rep   = data;
      default: ;
    endcase
    repeat (3) @(negedge clk);
  endtask

  // one trigger edge, sample-by-sample comparison; optional mid-run action
  task automatic fire(input string req, input int inj_n, input int inj_kind,
                      input int inj_addr, input int inj_data);
    int len = (m_delay + m_width) * P + 1;
    int total = (m_rep + 1) * len + 3;
    int bad = 0, bad_n = 0, got = 0, exp = 0;
    @(negedge clk);
    trig_in = ~trig_in;
    for (int n = 1; n <= total; n++) begin
      @(negedge clk);
      if (pulse_o !== exp_pulse(n, m_delay, m_width, m_rep)) begin
        if (bad == 0) begin
          bad_n = n; got = int'(pulse_o); exp = int'(exp_pulse(n, m_delay, m_width, m_rep));
        end
        bad++;
      end
      cfg_we = 1'b0;
      if (n == inj_n && inj_kind == 1) trig_in = ~trig_in;
      if (n == inj_n && inj_kind == 2) begin
        cfg_we = 1'b1; cfg_addr = 3'(inj_addr); cfg_wdata = CNT_W'(inj_data);
      end
    end
    cfg_we = 1'b0;
    if (bad != 0) $display("  (first mismatch at sample %0d, delay %0d width %0d)", bad_n, m_delay, m_width);
    chk(bad == 0, req, got, exp);
    m_delay = next_delay(m_delay, m_step, m_min);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4242);
    reset_dut();
    // R10: reset state
    chk(pulse_o == 1'b0, "R10 pulse low after reset", int'(pulse_o), 0);
    chk(overrun_o == 1'b0, "R10 overrun clear after reset", int'(overrun_o), 0);
    repeat (20) @(negedge clk);
    chk(pulse_o == 1'b0, "R1 idle without trigger", int'(pulse_o), 0);
    // R10: defaults drive the first run; R2/R3 timing
    fire("R10 R2 R3 default run", 0, 0, 0, 0);

    // R6 and R1 both edges: 9,6,3,2,2
    wr(0, 9); wr(1, 3); wr(2, 2); wr(3, 3); wr(4, 0);
    fire("R6 R1 rising/falling delay 9", 0, 0, 0, 0);
    fire("R6 delay 6", 0, 0, 0, 0);
    fire("R6 delay 3", 0, 0, 0, 0);
    fire("R6 clamp to floor", 0, 0, 0, 0);
    fire("R6 hold at floor", 0, 0, 0, 0);

    // R5: width written mid-run leaves this run alone
    fire("R5 width write mid-run", 5, 2, 3, 6);
    m_width = 6;
    fire("R5 new width next run", 0, 0, 0, 0);

    // R7: start written mid-run reloads next run
    fire("R7 start write mid-run", 4, 2, 0, 7);
    m_delay = 7;
    fire("R7 reloaded start delay", 0, 0, 0, 0);

    // R4: zero width
    wr(3, 0);
    fire("R4 zero width no pulse", 0, 0, 0, 0);
    fire("R4 zero width sequence advances", 0, 0, 0, 0);

    // R8: repeats
    wr(0, 5); wr(3, 2); wr(4, 2);
    fire("R8 three pulses per run", 0, 0, 0, 0);
    fire("R8 repeats after decrement", 0, 0, 0, 0);
    wr(4, 0);

    // R9: extra edge during run
    chk(overrun_o == 1'b0, "R9 overrun clear before", int'(overrun_o), 0);
    wr(0, 6);
    fire("R9 mid-run edge ignored", 10, 1, 0, 0);
    chk(overrun_o == 1'b1, "R9 overrun set", int'(overrun_o), 1);
    fire("R9 next run normal", 0, 0, 0, 0);
    chk(overrun_o == 1'b1, "R9 overrun sticky", int'(overrun_o), 1);

    // R11: unmapped addresses have no effect
    wr(5, 0); wr(6, 1); wr(7, 40);
    fire("R11 unmapped writes ignored", 0, 0, 0, 0);

    // random configurations
    for (int it = 0; it < 24; it++) begin
      if ($urandom_range(1, 0) == 1) wr(0, int'($urandom_range(12, 0)));
      if ($urandom_range(1, 0) == 1) wr(1, int'($urandom_range(5, 0)));
      if ($urandom_range(1, 0) == 1) wr(2, int'($urandom_range(6, 0)));
      if ($urandom_range(1, 0) == 1) wr(3, int'($urandom_range(6, 0)));
      if ($urandom_range(1, 0) == 1) wr(4, int'($urandom_range(2, 0)));
      if (m_delay > 40) wr(0, 10);
      fire("R2 R3 R6 R8 random run", 0, 0, 0, 0);
      fire("R2 R3 R6 R8 random follow-up", 0, 0, 0, 0);
    end

    // R10: reset restores defaults and clears overrun
    reset_dut();
    chk(overrun_o == 1'b0, "R10 overrun cleared by reset", int'(overrun_o), 0);
    fire("R10 default delay after reset", 0, 0, 0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule